// File: doc/BRIEF.md
# Two-Read One-Write Register File with Optional Forwarding

This block stores a small set of equal-width registers behind one write port and two read ports. A write takes effect at a rising clock edge when the write enable is high, and only the register named by the write select changes. Each read port has its own select and drives its data output purely combinationally, so a new select is reflected on the output within the same cycle. No tri-state drivers are used.

A build-time parameter chooses between two behaviours. In plain mode a read that selects the register being written in the current cycle returns the contents from before the edge. In forwarding mode a thin layer around the same storage steers the incoming write data onto any read port whose select matches the write select while the write enable is high, so a value produced in one cycle is readable in that cycle. Both modes share one port list, and the storage is built from one single-register module per entry plus decode and selection logic. The register count and the width are parameters (default 8 registers of 16 bits, 3-bit selects).

Top module: `rf_2r1w`

## Requirements
- R1: While rst_ni is low every register is zero and both read outputs show zero for a non-forwarded read; the reset acts without waiting for a clock edge.
- R2: With wr_en_i high at a rising edge, the register numbered wr_sel_i holds wr_data_i after that edge.
- R3: With wr_en_i low at a rising edge, no register changes.
- R4: A write changes only the register numbered wr_sel_i; at most one register loads on any edge.
- R5: Each read port outputs the register numbered by its own select in the same cycle the select is applied, independently of the other port and of wr_en_i.
- R6: With FORWARD = 0, a read port whose select equals wr_sel_i while wr_en_i is high outputs the contents from before the edge, not wr_data_i.
- R7: With FORWARD = 1, a read port whose select equals wr_sel_i while wr_en_i is high outputs wr_data_i in that same cycle.
- R8: With FORWARD = 1, the forwarding decision is made per port: one port may forward while the other returns stored data.
- R9: When rst_ni is low together with a write, the register stays zero; with FORWARD = 1 a matching read port still shows wr_data_i during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all registers |
| wr_en_i | input | 1 | Write enable, active high |
| wr_sel_i | input | SEL_W (3) | Number of the register to write |
| wr_data_i | input | DATA_W (16) | Data to write |
| rd0_sel_i | input | SEL_W (3) | Number of the register read on port 0 |
| rd1_sel_i | input | SEL_W (3) | Number of the register read on port 1 |
| rd0_data_o | output | DATA_W (16) | Read data, port 0 |
| rd1_data_o | output | DATA_W (16) | Read data, port 1 |

## Verification
On every cycle the assertions confirm that the load decode never enables more than one register, that a write lands in the selected register by the next edge, that an idle register keeps its value, and, in forwarding mode, that a matching port carries the write data. Whether plain mode withholds the write data in the write cycle, whether the two ports forward independently, and how reset interacts with a concurrent write are shown only by the bench's scenarios, which run a plain and a forwarding instance side by side against one behavioural model and exercise every register with walking-one and walking-zero patterns.

// File: rtl/rf_pkg.sv
package rf_pkg;
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rf_word.sv
module rf_word #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> q_o == $past(q_o));
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int SEL_W    = rf_pkg::sel_width(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd0_sel_i,
  input  logic [SEL_W-1:0]  rd1_sel_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic [DATA_W-1:0] rd1_data_o
);
  logic [NUM_REGS-1:0] ld;
  logic [DATA_W-1:0]   q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    assign ld[i] = wr_en_i && (wr_sel_i == SEL_W'(i));
    rf_word #(.DATA_W(DATA_W)) i_word (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (ld[i]),
      .d_i   (wr_data_i),
      .q_o   (q[i])
    );
  end

  // unmapped selects read as zero
  always_comb begin
    rd0_data_o = '0;
    rd1_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd0_sel_i == SEL_W'(i)) rd0_data_o = q[i];
      if (rd1_sel_i == SEL_W'(i)) rd1_data_o = q[i];
    end
  end

  // R4
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld));

  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_sel_i) < NUM_REGS)) |=> q[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: rtl/rf_fwd.sv
module rf_fwd #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic hit;
  assign hit       = wr_en_i && (rd_sel_i == wr_sel_i);
  assign rd_data_o = hit ? wr_data_i : stored_i;
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter bit FORWARD  = 1'b1,
  localparam int SEL_W   = rf_pkg::sel_width(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd0_sel_i,
  input  logic [SEL_W-1:0]  rd1_sel_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic [DATA_W-1:0] rd1_data_o
);
  logic [DATA_W-1:0] st0, st1;

  rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd0_sel_i (rd0_sel_i),
    .rd1_sel_i (rd1_sel_i),
    .rd0_data_o(st0),
    .rd1_data_o(st1)
  );

  if (FORWARD) begin : g_fwd
    rf_fwd #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_fwd0 (
      .wr_en_i  (wr_en_i),
      .wr_sel_i (wr_sel_i),
      .wr_data_i(wr_data_i),
      .rd_sel_i (rd0_sel_i),
      .stored_i (st0),
      .rd_data_o(rd0_data_o)
    );
    rf_fwd #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_fwd1 (
      .wr_en_i  (wr_en_i),
      .wr_sel_i (wr_sel_i),
      .wr_data_i(wr_data_i),
      .rd_sel_i (rd1_sel_i),
      .stored_i (st1),
      .rd_data_o(rd1_data_o)
    );

    // R7
    fwd_port0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && rd0_sel_i == wr_sel_i) |-> rd0_data_o == wr_data_i);
    // R7
    fwd_port1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && rd1_sel_i == wr_sel_i) |-> rd1_data_o == wr_data_i);
  end else begin : g_plain
    assign rd0_data_o = st0;
    assign rd1_data_o = st1;
  end
endmodule

// File: tb/test_rf_2r1w.sv
module test_rf_2r1w;
  localparam int N = 8;
  localparam int W = 16;
  localparam int S = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [S-1:0] wr_sel = '0, rd0_sel = '0, rd1_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] f0, f1, p0, p1;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] mdl [N];

  always #10 clk = ~clk;

  rf_2r1w #(.NUM_REGS(N), .DATA_W(W), .FORWARD(1'b1)) i_rf_2r1w (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd0_sel_i(rd0_sel), .rd1_sel_i(rd1_sel),
    .rd0_data_o(f0), .rd1_data_o(f1));

  rf_2r1w #(.NUM_REGS(N), .DATA_W(W), .FORWARD(1'b0)) i_rf_2r1w_plain (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd0_sel_i(rd0_sel), .rd1_sel_i(rd1_sel),
    .rd0_data_o(p0), .rd1_data_o(p1));

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check mid-low phase, update model at posedge
  task automatic cyc(input logic rst, input logic we, input int ws, input logic [W-1:0] wd,
                     input int r0, input int r1, input string tag);
    logic [W-1:0] e0, e1;
    bit h0, h1;
    @(negedge clk);
    rst_ni = rst; wr_en = we; wr_sel = S'(ws); wr_data = wd;
    rd0_sel = S'(r0); rd1_sel = S'(r1);
    if (!rst) for (int i = 0; i < N; i++) mdl[i] = '0;
    #5;
    h0 = we && (r0 == ws);
    h1 = we && (r1 == ws);
    e0 = mdl[r0];
    e1 = mdl[r1];
    cmp(h0 ? "R6 plain port0" : {tag, " plain port0"}, p0, e0);
    cmp(h1 ? "R6 plain port1" : {tag, " plain port1"}, p1, e1);
    cmp(h0 ? (rst ? "R7 fwd port0" : "R9 fwd port0") : {tag, " fwd port0"}, f0, h0 ? wd : e0);
    cmp(h1 ? (rst ? "R8 fwd port1" : "R9 fwd port1") : {tag, " fwd port1"}, f1, h1 ? wd : e1);
    @(posedge clk);
    if (rst && we) mdl[ws] = wd;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    // R1: reset state, all selects
    for (int i = 0; i < N; i++) cyc(1'b0, 1'b0, 0, '0, i, N-1-i, "R1");
    // R2 R4: walking ones then walking zeros through every register, read back on both ports
    for (int b = 0; b < W; b++) begin
      for (int i = 0; i < N; i++) cyc(1'b1, 1'b1, i, W'(1) << ((b + i) % W), (i + 1) % N, (i + 3) % N, "R4");
      for (int i = 0; i < N; i++) cyc(1'b1, 1'b0, 0, '0, i, (i + 5) % N, "R2");
      for (int i = 0; i < N; i++) cyc(1'b1, 1'b1, i, ~(W'(1) << ((b + i) % W)), (i + 2) % N, (i + 6) % N, "R4");
      for (int i = 0; i < N; i++) cyc(1'b1, 1'b0, 0, '0, (i + 4) % N, i, "R2");
    end
    // R3: enable low with data and select toggling, then read all
    for (int i = 0; i < N; i++) cyc(1'b1, 1'b0, i, 16'hdead ^ W'(i), i, i, "R3");
    for (int i = 0; i < N; i++) cyc(1'b1, 1'b0, 0, '0, i, (i + 1) % N, "R3");
    // R6 R7: both ports read the register being written
    for (int i = 0; i < N; i++) begin
      cyc(1'b1, 1'b1, i, 16'h5a00 | W'(i), i, i, "R7");
      cyc(1'b1, 1'b0, 0, '0, i, i, "R2");
    end
    // R8: port0 matches, port1 elsewhere and vice versa
    for (int i = 0; i < N; i++) begin
      cyc(1'b1, 1'b1, i, 16'hc3c0 | W'(i), i, (i + 1) % N, "R8");
      cyc(1'b1, 1'b1, i, 16'h3c30 | W'(i), (i + 2) % N, i, "R8");
    end
    // R5: select changes with no write
    for (int i = 0; i < 2 * N; i++) cyc(1'b1, 1'b0, 0, '0, (i * 3) % N, (i * 5) % N, "R5");
    // R9: reset together with write, then confirm registers stayed zero
    cyc(1'b0, 1'b1, 3, 16'hbeef, 3, 4, "R9");
    cyc(1'b0, 1'b1, 5, 16'h1234, 2, 5, "R9");
    for (int i = 0; i < N; i++) cyc(1'b1, 1'b0, 0, '0, i, i, "R9");
    // R5: mixed random traffic
    for (int k = 0; k < 400; k++)
      cyc(1'b1, 1'($urandom), int'($urandom % N), W'($urandom), int'($urandom % N),
          int'($urandom % N), "R5");
    finish_run();
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule